// File: doc/BRIEF.md
# IF Counter Search-Stop Discriminator

This block decides whether the limited intermediate-frequency signal of a tuner lies close enough to its nominal value to stop a station seek. A programmable timer running on the oscillator clock opens a measurement gate of known length. During that gate every rising edge of the synchronised IF input steps a down counter. The counter was preloaded from a trimmed nominal count, so at gate close its residue shows how far the IF frequency is from nominal. The residue is compared with a power-of-two tolerance window. The outcome is reported as a pass/fail result, and a pass raises the search-stop line.

The gate length is the timer base period (reload + 1 oscillator cycles) multiplied by a power-of-two sampling factor. The nominal count follows the band (FM or AM upconversion) and a centre trim. The counter length grows with the band and the sampling factor. Measurements are taken only while the synthesizer reports lock and software enables the block. They repeat back to back, and each one takes a fresh copy of the settings.

Top module: `ifc_seek_disc`

## Requirements
- R1: While armed, `gate_o` is high for exactly (timer_reload + 1) × 2^samp_sel consecutive clock cycles per measurement.
- R2: No gate opens and no result is produced unless `pll_lock` and `meas_en` are both high. Once both are high, a measurement starts by itself.
- R3: The nominal count N is (BASE + cf_trim) × 2^samp_sel. BASE is FM_BASE when `am_mode` = 0 and AM_BASE when `am_mode` = 1 (defaults 1697 and 10689).
- R4: Let K be the number of rising edges of `if_in` inside the gate. The measurement passes when |K − N| ≤ 2^win_sel and fails otherwise, in both bands and for every sampling select.
- R5: Each result appears as a one-cycle `meas_done` pulse, together with `meas_pass`, two cycles after the last gate cycle. The next gate opens on the following cycle, so consecutive `meas_done` pulses are (gate length + 2) cycles apart.
- R6: `search_stop` goes high on the result cycle of a passing measurement. It stays high through later failing measurements for as long as the block stays armed.
- R7: `search_stop` is cleared, and the running measurement is abandoned, on the clock edge at which `pll_lock` is low, `meas_en` is low, or `am_mode` differs from its value one cycle earlier.
- R8: During and right after reset, `gate_o`, `meas_done`, `meas_pass` and `search_stop` are low.
- R9: Changes to timer_reload, samp_sel, cf_trim or win_sel while a gate is open do not affect that measurement. They take effect at the next gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| if_in | input | 1 | Limited IF signal, asynchronous to clk and below clk/2 |
| pll_lock | input | 1 | Synthesizer lock flag |
| meas_en | input | 1 | Software enable |
| am_mode | input | 1 | Band select: 0 = FM, 1 = AM upconversion |
| timer_reload | input | TMR_W | Gate timer reload; base period = value + 1 cycles |
| samp_sel | input | SEL_W | Sampling factor 2^samp_sel |
| cf_trim | input | CF_W | Centre trim added to the nominal base |
| win_sel | input | EW_W | Tolerance 2^win_sel IF counts |
| gate_o | output | 1 | High while the measurement gate is open |
| meas_done | output | 1 | One-cycle pulse when a result is valid |
| meas_pass | output | 1 | Result of the last measurement |
| search_stop | output | 1 | Seek stop line |

## Verification
The bench builds the block with FM_BASE = 6, AM_BASE = 12, CF_W = 3, SEL_W = 2 and TMR_W = 8. With these values the down counter is only 4 to 8 bits long, and one gate takes a few dozen to a few hundred cycles. That makes it possible to sweep both bands, every sampling select and the lower window selects across IF counts on both sides of each tolerance edge, and to reach counter wrap and deep under-count cases in a short run. The IF input toggles with a fixed half period, and the gate lengths are chosen so that each gate holds a whole number of IF periods. The expected count is then exact, and the pass/fail outcome follows from plain arithmetic in the bench.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    // Measurement sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_GATE = 2'd2,
        ST_EVAL = 2'd3
    } ifc_state_e;

    // Band encoding on the mode input.
    typedef enum logic {
        BAND_FM = 1'b0,
        BAND_AM = 1'b1
    } ifc_band_e;

    // Number of bits needed to hold value v.
    function automatic int unsigned bits_for(input int unsigned v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            if ((v >> i) != 0) n = i + 1;
        end
        return n;
    endfunction

    // Counter bits for one base period: the largest trimmed nominal.
    function automatic int unsigned span_for(input int unsigned base,
                                             input int unsigned trim_w);
        return bits_for(base + (32'd1 << trim_w) - 32'd1);
    endfunction

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic rise
);
    // sr[STAGES-1] is the synchronised level, sr[STAGES] its delayed copy.
    logic [STAGES:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-1:0], raw};
    end

    always_comb rise = sr[STAGES-1] & ~sr[STAGES];

endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
    parameter int TMR_W = 14,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [TMR_W-1:0] reload,
    input  logic [SEL_W-1:0] sel,
    output logic             active,
    output logic             last
);
    localparam int DIV_W = 1 << SEL_W;

    logic [TMR_W-1:0] tmr_q, reload_q;
    logic [DIV_W-1:0] div_q, lim_q;
    logic             act_q;

    always_comb last = act_q && (tmr_q == '0) && (div_q == lim_q);
    always_comb active = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            tmr_q    <= '0;
            reload_q <= '0;
            div_q    <= '0;
            lim_q    <= '0;
        end else if (abort) begin
            act_q <= 1'b0;
        end else if (start) begin
            act_q    <= 1'b1;
            tmr_q    <= reload;
            reload_q <= reload;
            div_q    <= '0;
            lim_q    <= (DIV_W'(1) << sel) - DIV_W'(1);
        end else if (act_q) begin
            if (last) begin
                act_q <= 1'b0;
            end else if (tmr_q == '0) begin
                tmr_q <= reload_q;
                div_q <= div_q + DIV_W'(1);
            end else begin
                tmr_q <= tmr_q - TMR_W'(1);
            end
        end
    end

endmodule

// File: rtl/ifc_down_count.sv
module ifc_down_count #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] preload,
    input  logic [CNT_W-1:0] mask_ld,
    input  logic [CNT_W-1:0] mask_run,
    output logic [CNT_W-1:0] value,
    output logic [1:0]       wraps
);
    // Down counter of variable length (set by mask). Wraps saturate at 2.
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            wraps <= 2'd0;
        end else if (load) begin
            value <= preload & mask_ld;
            wraps <= 2'd0;
        end else if (step) begin
            value <= (value - CNT_W'(1)) & mask_run;
            if (value == '0 && wraps != 2'd2) wraps <= wraps + 2'd1;
        end
    end

endmodule

// File: rtl/ifc_window_judge.sv
module ifc_window_judge #(
    parameter int CNT_W = 21,
    parameter int TOL_W = 8
) (
    input  logic [CNT_W-1:0] value,
    input  logic [1:0]       wraps,
    input  logic [CNT_W-1:0] mask,
    input  logic [TOL_W-1:0] tol,
    output logic             hit
);
    localparam int CMP_W = ((CNT_W > TOL_W) ? CNT_W : TOL_W) + 1;

    logic [CMP_W-1:0] v, m, t;
    logic             under_ok, over_ok;

    always_comb begin
        v = CMP_W'(value);
        m = CMP_W'(mask);
        t = CMP_W'(tol);
        // No wrap: short by (value + 1) counts.
        under_ok = (wraps == 2'd0) && (v < t);
        // One wrap: over by (mask - value) counts.
        over_ok  = (wraps == 2'd1) && ((v + t) >= m);
        hit      = under_ok | over_ok;
    end

endmodule

// File: rtl/ifc_seek_disc.sv
module ifc_seek_disc #(
    parameter int TMR_W   = 14,
    parameter int SEL_W   = 3,
    parameter int CF_W    = 5,
    parameter int EW_W    = 3,
    parameter int FM_BASE = 1697,
    parameter int AM_BASE = 10689,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             if_in,
    input  logic             pll_lock,
    input  logic             meas_en,
    input  logic             am_mode,
    input  logic [TMR_W-1:0] timer_reload,
    input  logic [SEL_W-1:0] samp_sel,
    input  logic [CF_W-1:0]  cf_trim,
    input  logic [EW_W-1:0]  win_sel,
    output logic             gate_o,
    output logic             meas_done,
    output logic             meas_pass,
    output logic             search_stop
);
    import ifc_pkg::*;

    localparam int FM_SPAN  = int'(span_for(FM_BASE, CF_W));
    localparam int AM_SPAN  = int'(span_for(AM_BASE, CF_W));
    localparam int MAX_SPAN = (FM_SPAN > AM_SPAN) ? FM_SPAN : AM_SPAN;
    localparam int CNT_W    = MAX_SPAN + (1 << SEL_W) - 1;
    localparam int TOL_W    = 1 << EW_W;

    typedef struct packed {
        logic [CNT_W-1:0] mask;
        logic [TOL_W-1:0] tol;
    } win_cfg_t;

    ifc_state_e        state_q;
    win_cfg_t          cfg_q;
    logic              mode_q;
    logic              armed;
    logic              if_rise;
    logic              t_active, t_last, t_start;
    logic              hit;
    logic [CNT_W-1:0]  base_w, nom_w, preload_w, mask_w, cnt_v;
    logic [TOL_W-1:0]  tol_w;
    logic [1:0]        cnt_wraps;
    int                len_w;

    // Armed only while locked, enabled and with an unchanged band.
    always_comb armed = pll_lock && meas_en && (am_mode == mode_q);

    // Nominal count, counter length and tolerance from the live settings.
    always_comb begin
        base_w    = (am_mode == BAND_AM) ? CNT_W'(AM_BASE) : CNT_W'(FM_BASE);
        nom_w     = (base_w + CNT_W'(cf_trim)) << samp_sel;
        preload_w = nom_w - CNT_W'(1);
        len_w     = ((am_mode == BAND_AM) ? AM_SPAN : FM_SPAN) + int'(samp_sel);
        mask_w    = {CNT_W{1'b1}} >> (CNT_W - len_w);
        tol_w     = TOL_W'(1) << win_sel;
    end

    always_comb t_start = armed && (state_q == ST_LOAD);

    ifc_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (if_in),
        .rise (if_rise)
    );

    ifc_gate_timer #(.TMR_W(TMR_W), .SEL_W(SEL_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (t_start),
        .abort  (!armed),
        .reload (timer_reload),
        .sel    (samp_sel),
        .active (t_active),
        .last   (t_last)
    );

    ifc_down_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_LOAD),
        .step     (if_rise && t_active),
        .preload  (preload_w),
        .mask_ld  (mask_w),
        .mask_run (cfg_q.mask),
        .value    (cnt_v),
        .wraps    (cnt_wraps)
    );

    ifc_window_judge #(.CNT_W(CNT_W), .TOL_W(TOL_W)) u_judge (
        .value (cnt_v),
        .wraps (cnt_wraps),
        .mask  (cfg_q.mask),
        .tol   (cfg_q.tol),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '0;
            mode_q      <= 1'b0;
            meas_done   <= 1'b0;
            meas_pass   <= 1'b0;
            search_stop <= 1'b0;
        end else begin
            mode_q    <= am_mode;
            meas_done <= 1'b0;
            if (!armed) begin
                state_q     <= ST_IDLE;
                search_stop <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_q <= ST_LOAD;
                    ST_LOAD: begin
                        cfg_q.mask <= mask_w;
                        cfg_q.tol  <= tol_w;
                        state_q    <= ST_GATE;
                    end
                    ST_GATE: if (t_last) state_q <= ST_EVAL;
                    ST_EVAL: begin
                        meas_pass <= hit;
                        meas_done <= 1'b1;
                        if (hit) search_stop <= 1'b1;
                        state_q <= ST_LOAD;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb gate_o = t_active;

endmodule

// File: rtl/ifc_seek_disc_chk.sv
module ifc_seek_disc_chk (
    input logic clk,
    input logic rst,
    input logic pll_lock,
    input logic meas_en,
    input logic am_mode,
    input logic gate_o,
    input logic meas_done,
    input logic meas_pass,
    input logic search_stop
);
    AST_GATE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        !pll_lock |=> !gate_o); // R2

    AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !meas_en |=> !gate_o); // R2

    AST_DONE_AFTER_GATE: assert property (@(posedge clk) disable iff (rst)
        meas_done |-> (!gate_o && $past(gate_o, 2))); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        meas_done |=> !meas_done); // R5

    AST_STOP_ON_PASS: assert property (@(posedge clk) disable iff (rst)
        $rose(search_stop) |-> (meas_done && meas_pass)); // R6

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (search_stop && pll_lock && meas_en && $stable(am_mode)) |=> search_stop); // R6

    AST_STOP_CLR_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (!pll_lock || !meas_en) |=> !search_stop); // R7

    AST_STOP_CLR_MODE: assert property (@(posedge clk) disable iff (rst)
        (am_mode != $past(am_mode)) |=> !search_stop); // R7

    always_comb begin
        if (rst) begin
            AST_RESET_QUIET: assert (!meas_done || $isunknown(meas_done)); // R8
        end
    end

endmodule

bind ifc_seek_disc ifc_seek_disc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pll_lock    (pll_lock),
    .meas_en     (meas_en),
    .am_mode     (am_mode),
    .gate_o      (gate_o),
    .meas_done   (meas_done),
    .meas_pass   (meas_pass),
    .search_stop (search_stop)
);

// File: tb/sim_ifc_seek_disc.sv
module sim_ifc_seek_disc;
    localparam int TMR_W = 8;
    localparam int SEL_W = 2;
    localparam int CF_W  = 3;
    localparam int EW_W  = 3;
    localparam int FMB   = 6;
    localparam int AMB   = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             if_in = 1'b0;
    logic             pll_lock = 1'b1;
    logic             meas_en = 1'b0;
    logic             am_mode = 1'b0;
    logic [TMR_W-1:0] timer_reload = '0;
    logic [SEL_W-1:0] samp_sel = '0;
    logic [CF_W-1:0]  cf_trim = '0;
    logic [EW_W-1:0]  win_sel = '0;
    logic             gate_o, meas_done, meas_pass, search_stop;

    int n_chk = 0;
    int n_fail = 0;
    int half = 1;
    int hc = 0;
    int cyc = 0;
    int glen = 0;
    int last_glen = 0;
    bit gate_seen = 0;
    bit done_seen = 0;

    always #10 clk = ~clk;

    ifc_seek_disc #(
        .TMR_W(TMR_W), .SEL_W(SEL_W), .CF_W(CF_W), .EW_W(EW_W),
        .FM_BASE(FMB), .AM_BASE(AMB)
    ) u0 (
        .clk(clk), .rst(rst), .if_in(if_in), .pll_lock(pll_lock),
        .meas_en(meas_en), .am_mode(am_mode), .timer_reload(timer_reload),
        .samp_sel(samp_sel), .cf_trim(cf_trim), .win_sel(win_sel),
        .gate_o(gate_o), .meas_done(meas_done), .meas_pass(meas_pass),
        .search_stop(search_stop)
    );

    // IF source: toggles every 'half' cycles, away from the active edge.
    always @(negedge clk) begin
        if (hc >= half - 1) begin
            if_in <= ~if_in;
            hc <= 0;
        end else begin
            hc <= hc + 1;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Gate length and activity monitor.
    always @(negedge clk) begin
        if (gate_o) begin
            glen = glen + 1;
            gate_seen = 1;
        end else if (glen != 0) begin
            last_glen = glen;
            glen = 0;
        end
        if (meas_done) done_seen = 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        int n;
        n = 0;
        ok = 0;
        while (n < 5000) begin
            @(negedge clk);
            if (meas_done) begin
                ok = 1;
                break;
            end
            n++;
        end
    endtask

    task automatic setup(input bit am, input int sel, input int ew,
                         input int cf, input int m);
        @(negedge clk);
        meas_en      = 1'b0;
        am_mode      = am;
        samp_sel     = SEL_W'(sel);
        win_sel      = EW_W'(ew);
        cf_trim      = CF_W'(cf);
        timer_reload = TMR_W'(m - 1);
        @(negedge clk);
        @(negedge clk);
        meas_en = 1'b1;
    endtask

    // One full measurement with its checks against the window arithmetic.
    task automatic measure(input bit am, input int sel, input int ew,
                           input int cf, input int m);
        bit ok;
        int g, k, n, d;
        bit exp;
        setup(am, sel, ew, cf, m);
        wait_done(ok);
        check(ok, "R2", "result after arming", int'(ok), 1);
        g = m << sel;
        k = g / (2 * half);
        n = ((am ? AMB : FMB) + cf) << sel;
        d = (k > n) ? k - n : n - k;
        exp = (d <= (1 << ew));
        check(last_glen == g, "R1", "gate length", last_glen, g);
        if (d == 0)
            check(meas_pass == 1'b1, "R3", "nominal count passes", int'(meas_pass), 1);
        else
            check(meas_pass == exp, "R4", "window result", int'(meas_pass), int'(exp));
        check(search_stop == exp, "R6", "search stop after result",
              int'(search_stop), int'(exp));
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        bit ok;
        int c1;
        // R8: quiet reset, even with lock and enable already high.
        meas_en = 1'b1;
        repeat (5) @(negedge clk);
        check({gate_o, meas_done, meas_pass, search_stop} == 4'b0, "R8",
              "outputs in reset", int'({gate_o, meas_done, meas_pass, search_stop}), 0);
        meas_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check({gate_o, meas_done, meas_pass, search_stop} == 4'b0, "R8",
              "outputs after reset", int'({gate_o, meas_done, meas_pass, search_stop}), 0);

        // R2: no gate without lock.
        setup(1'b0, 1, 0, 2, 16);
        pll_lock = 1'b0;
        @(negedge clk);
        gate_seen = 0;
        done_seen = 0;
        repeat (300) @(negedge clk);
        check(!gate_seen && !done_seen, "R2", "idle without lock",
              int'(gate_seen | done_seen), 0);
        pll_lock = 1'b1;
        wait_done(ok);
        check(ok, "R2", "starts once locked", int'(ok), 1);

        // Main sweep, IF at clk/2: both bands, all selects, low windows.
        for (int am = 0; am < 2; am++)
            for (int sel = 0; sel < 4; sel++)
                for (int ew = 0; ew < 3; ew++) begin
                    int cf, m0;
                    cf = (sel * 3 + ew + am) % 8;
                    m0 = ((am != 0 ? AMB : FMB) + cf) * 2;
                    for (int d = -8; d <= 8; d++) begin
                        int m;
                        m = m0 + d;
                        if (((m << sel) % 2) != 0) continue;
                        measure(am[0], sel, ew, cf, m);
                    end
                end

        // Slower IF (period of 4 clocks), AM band, R4 window edges.
        half = 2;
        for (int d = -8; d <= 8; d++) begin
            int m;
            m = (AMB + 5) * 4 + d;
            if (((m << 1) % 4) != 0) continue;
            measure(1'b1, 1, 1, 5, m);
        end
        half = 1;

        // R9: settings changed mid-gate do not touch the running measurement.
        setup(1'b0, 1, 0, 2, 16);
        while (!gate_o) @(negedge clk);
        timer_reload = TMR_W'(39);
        wait_done(ok);
        check(ok && meas_pass, "R9", "result uses captured settings", int'(meas_pass), 1);
        check(last_glen == 32, "R9", "gate uses captured reload", last_glen, 32);
        // R6: the next measurement fails, search stop holds.
        wait_done(ok);
        c1 = cyc;
        check(ok && !meas_pass, "R6", "later result fails", int'(meas_pass), 0);
        check(search_stop == 1'b1, "R6", "search stop sticky", int'(search_stop), 1);
        // R5: back-to-back results spaced by gate + 2.
        wait_done(ok);
        check(ok && (cyc - c1) == 82, "R5", "result spacing", cyc - c1, 82);

        // R7: lock loss, enable drop and band change clear search stop.
        measure(1'b0, 1, 0, 2, 16);
        pll_lock = 1'b0;
        @(negedge clk);
        check(!search_stop && !gate_o, "R7", "cleared on lock loss", int'(search_stop), 0);
        pll_lock = 1'b1;
        measure(1'b0, 1, 0, 2, 16);
        meas_en = 1'b0;
        @(negedge clk);
        check(!search_stop, "R7", "cleared on enable drop", int'(search_stop), 0);
        measure(1'b0, 1, 0, 2, 16);
        am_mode = 1'b1;
        @(negedge clk);
        check(!search_stop && !gate_o, "R7", "cleared on band change", int'(search_stop), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule